// File: doc/BRIEF.md
# Adaptive Black Level Expander

This block sits in a luminance path and deepens the dark end of the picture only when the picture has enough contrast to benefit. A smoothed copy of the incoming luma is produced by a first-order recursive low-pass filter. The lowest and highest smoothed values seen during a field are recorded. When the next field begins, a knee level is placed between those two extremes at a programmable fraction of the span. For the whole following field, any pixel darker than the knee is moved further toward black. The amount of that move grows with the pixel's distance below the knee and with a programmable gain.

A programmable ceiling limits the knee, so pixels at or above the ceiling are never altered. A per-pixel bypass input lets upstream logic exempt individual pixels, for example inserted graphics. When the picture is flat, the two extremes nearly coincide and the knee falls at the darkest level present, so almost nothing is changed. Results appear three clock cycles after the input, and the output valid flag follows the input valid flag with the same delay.

Top module: `black_level_expander`

## Requirements
- R1: After reset, `out_valid` is 0 and the knee level is 0, so every pixel passes unchanged until the first field boundary that closes a field containing samples.
- R2: `out_valid` equals `in_valid` from exactly 3 cycles earlier, and `out_luma` then carries the result for that earlier pixel.
- R3: On each valid pixel the smoothed value s (0 after reset) is updated as s = s + floor((in_luma - s) / 8). Extremes are tracked on the updated s.
- R4: When `field_start` is high, the knee becomes min + floor(`cfg_tilt_frac` x (max - min) / 16), where min and max are the extremes of s over the field just closed. Tracking then restarts, and the new knee applies to pixels entering from the next cycle on.
- R5: A field boundary that closes a field with no valid pixels leaves the knee unchanged.
- R6: With effective knee K, a pixel L below K (and not bypassed) gives L + floor(`cfg_expand_gain` x (L - K) / 16), limited below at 0.
- R7: A pixel at or above the effective knee is passed unchanged.
- R8: The effective knee is the smaller of the measured knee and `cfg_expand_cap`, so no pixel at or above `cfg_expand_cap` is altered.
- R9: A pixel presented with `bypass` high is passed unchanged.
- R10: An expansion gain of 0 leaves every pixel unchanged, and a fraction of 0 puts the knee at the field minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present on `in_luma` |
| in_luma | input | 10 | Input luminance, unsigned |
| field_start | input | 1 | One-cycle strobe at each field boundary |
| bypass | input | 1 | Per-pixel exemption from expansion |
| cfg_tilt_frac | input | 4 | Knee position within the measured span, in sixteenths |
| cfg_expand_gain | input | 4 | Expansion strength, in sixteenths |
| cfg_expand_cap | input | 10 | Ceiling on the knee level |
| out_valid | output | 1 | `in_valid` delayed by 3 cycles |
| out_luma | output | 10 | Processed luminance |

## Verification
The fields used as stimulus alternate a dark run and a bright run. Probe pixels are placed below the knee, above it, above the ceiling, and with bypass set. This separates a correct knee position from a wrong fraction, a wrong filter recurrence, or a ceiling that is not honoured. Single-sample fields isolate the filter value. A field with a very wide span combined with full gain drives the result below zero, which exposes a missing clamp. An empty field between two boundaries and zero-gain and zero-fraction settings show whether the knee is held and whether the degenerate settings leave pixels alone.

// File: rtl/blx_pkg.sv
package blx_pkg;
    localparam int LUMA_W = 10;
    localparam int FRAC_W = 4;
    localparam int EXT_W  = LUMA_W + FRAC_W + 2;
    localparam logic [LUMA_W-1:0] LUMA_MAX = {LUMA_W{1'b1}};

    typedef logic [LUMA_W-1:0]        luma_t;
    typedef logic [FRAC_W-1:0]        frac_t;
    typedef logic signed [EXT_W-1:0]  wide_t;

    typedef struct packed {
        logic  valid;
        logic  pass;
        frac_t gain;
        luma_t luma;
        luma_t knee;
    } stage_a_t;

    typedef struct packed {
        logic  valid;
        wide_t sum;
    } stage_b_t;

    function automatic luma_t knee_from_range(luma_t lo, luma_t hi, frac_t frac);
        luma_t                     span;
        logic [LUMA_W+FRAC_W-1:0]  prod;
        span = hi - lo;
        prod = frac * span;
        return lo + luma_t'(prod >> FRAC_W);
    endfunction

    function automatic wide_t expand_value(luma_t lin, luma_t knee, frac_t gain, logic pass);
        wide_t lin_w;
        wide_t diff;
        wide_t prod;
        lin_w = $signed({{(EXT_W-LUMA_W){1'b0}}, lin});
        diff  = lin_w - $signed({{(EXT_W-LUMA_W){1'b0}}, knee});
        prod  = $signed({{(EXT_W-FRAC_W){1'b0}}, gain}) * diff;
        if (pass || lin >= knee)
            return lin_w;
        return lin_w + (prod >>> FRAC_W);
    endfunction

    function automatic luma_t clamp_luma(wide_t v);
        if (v < 0)
            return '0;
        if (v > $signed({{(EXT_W-LUMA_W){1'b0}}, LUMA_MAX}))
            return LUMA_MAX;
        return v[LUMA_W-1:0];
    endfunction
endpackage

// File: rtl/blx_lowpass.sv
module blx_lowpass
    import blx_pkg::*;
#(
    parameter int SHIFT = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  luma_t in_luma,
    output luma_t smooth_next
);
    luma_t                   acc_q;
    logic signed [LUMA_W:0]  delta;
    logic signed [LUMA_W:0]  step;
    logic signed [LUMA_W:0]  nxt;

    always_comb begin
        delta       = $signed({1'b0, in_luma}) - $signed({1'b0, acc_q});
        step        = delta >>> SHIFT;
        nxt         = $signed({1'b0, acc_q}) + step;
        smooth_next = nxt[LUMA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (in_valid)
            acc_q <= smooth_next;
    end
endmodule

// File: rtl/blx_range_tracker.sv
module blx_range_tracker
    import blx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sample_valid,
    input  luma_t sample,
    input  logic  field_start,
    input  frac_t tilt_frac,
    output luma_t knee
);
    luma_t lo_q;
    luma_t hi_q;
    logic  seen_q;
    luma_t knee_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= LUMA_MAX;
            hi_q   <= '0;
            seen_q <= 1'b0;
            knee_q <= '0;
        end else if (field_start) begin
            if (seen_q)
                knee_q <= knee_from_range(lo_q, hi_q, tilt_frac);
            lo_q   <= sample_valid ? sample : LUMA_MAX;
            hi_q   <= sample_valid ? sample : '0;
            seen_q <= sample_valid;
        end else if (sample_valid) begin
            if (sample < lo_q) lo_q <= sample;
            if (sample > hi_q) hi_q <= sample;
            seen_q <= 1'b1;
        end
    end

    assign knee = knee_q;
endmodule

// File: rtl/blx_expand_pipe.sv
module blx_expand_pipe
    import blx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  luma_t in_luma,
    input  logic  pass,
    input  luma_t knee,
    input  luma_t cap,
    input  frac_t gain,
    output logic  out_valid,
    output luma_t out_luma
);
    stage_a_t sa_q;
    stage_b_t sb_q;
    logic     oval_q;
    luma_t    oluma_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sa_q    <= '0;
            sb_q    <= '0;
            oval_q  <= 1'b0;
            oluma_q <= '0;
        end else begin
            sa_q.valid <= in_valid;
            sa_q.pass  <= pass;
            sa_q.gain  <= gain;
            sa_q.luma  <= in_luma;
            sa_q.knee  <= (knee < cap) ? knee : cap;

            sb_q.valid <= sa_q.valid;
            sb_q.sum   <= expand_value(sa_q.luma, sa_q.knee, sa_q.gain, sa_q.pass);

            oval_q  <= sb_q.valid;
            oluma_q <= clamp_luma(sb_q.sum);
        end
    end

    assign out_valid = oval_q;
    assign out_luma  = oluma_q;
endmodule

// File: rtl/black_level_expander.sv
module black_level_expander
    import blx_pkg::*;
#(
    parameter int LPF_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [LUMA_W-1:0]   in_luma,
    input  logic                field_start,
    input  logic                bypass,
    input  logic [FRAC_W-1:0]   cfg_tilt_frac,
    input  logic [FRAC_W-1:0]   cfg_expand_gain,
    input  logic [LUMA_W-1:0]   cfg_expand_cap,
    output logic                out_valid,
    output logic [LUMA_W-1:0]   out_luma
);
    luma_t smooth_w;
    luma_t knee_w;

    blx_lowpass #(.SHIFT(LPF_SHIFT)) u_lpf (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_luma     (in_luma),
        .smooth_next (smooth_w)
    );

    blx_range_tracker u_track (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (in_valid),
        .sample       (smooth_w),
        .field_start  (field_start),
        .tilt_frac    (cfg_tilt_frac),
        .knee         (knee_w)
    );

    blx_expand_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_luma   (in_luma),
        .pass      (bypass),
        .knee      (knee_w),
        .cap       (cfg_expand_cap),
        .gain      (cfg_expand_gain),
        .out_valid (out_valid),
        .out_luma  (out_luma)
    );
endmodule

// File: rtl/blx_checker.sv
module blx_checker
    import blx_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input luma_t in_luma,
    input logic  bypass,
    input luma_t cfg_expand_cap,
    input luma_t knee,
    input logic  out_valid,
    input luma_t out_luma
);
    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end
    assign warm = (age_q == 2'd3);

    // R1: output idle right after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) $fell(rst) |-> !out_valid);

    // R2: valid delayed by exactly three cycles
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R6: expansion never brightens a pixel
    a_r6_never_brighter: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_luma <= $past(in_luma, 3)));

    // R7: at or above the knee the pixel is untouched
    a_r7_at_or_above_knee: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && ($past(in_luma, 3) >= $past(knee, 3)))
            |-> (out_luma == $past(in_luma, 3)));

    // R8: at or above the ceiling the pixel is untouched
    a_r8_cap_respected: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && ($past(in_luma, 3) >= $past(cfg_expand_cap, 3)))
            |-> (out_luma == $past(in_luma, 3)));

    // R9: bypassed pixels are untouched
    a_r9_bypass_passes: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(bypass, 3)) |-> (out_luma == $past(in_luma, 3)));
endmodule

bind black_level_expander blx_checker u_blx_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_luma        (in_luma),
    .bypass         (bypass),
    .cfg_expand_cap (cfg_expand_cap),
    .knee           (knee_w),
    .out_valid      (out_valid),
    .out_luma       (out_luma)
);

// File: tb/black_level_expander_bench.sv
module black_level_expander_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [9:0] in_luma = '0;
    logic       field_start = 1'b0;
    logic       bypass = 1'b0;
    logic [3:0] cfg_tilt_frac = '0;
    logic [3:0] cfg_expand_gain = '0;
    logic [9:0] cfg_expand_cap = 10'd1023;
    logic       out_valid;
    logic [9:0] out_luma;

    always #10 clk = ~clk;

    black_level_expander u_black_level_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_luma(in_luma),
        .field_start(field_start), .bypass(bypass),
        .cfg_tilt_frac(cfg_tilt_frac), .cfg_expand_gain(cfg_expand_gain),
        .cfg_expand_cap(cfg_expand_cap), .out_valid(out_valid), .out_luma(out_luma)
    );

    typedef struct packed {
        logic [9:0] lo;
        logic [9:0] hi;
        logic [7:0] n;
        logic [3:0] frac;
        logic [3:0] gain;
        logic [9:0] cap;
        logic [9:0] probe;
        logic       byp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{10'd100, 10'd800, 8'd24, 4'd8,  4'd8,  10'd1023, 10'd200, 1'b0}, // R6 below knee
        '{10'd100, 10'd800, 8'd24, 4'd8,  4'd8,  10'd1023, 10'd900, 1'b0}, // R7 above knee
        '{10'd50,  10'd950, 8'd40, 4'd15, 4'd15, 10'd1023, 10'd2,   1'b0}, // R6 clamp at 0
        '{10'd100, 10'd800, 8'd24, 4'd8,  4'd8,  10'd150,  10'd300, 1'b0}, // R8 above ceiling
        '{10'd100, 10'd800, 8'd24, 4'd8,  4'd8,  10'd400,  10'd200, 1'b0}, // R8 ceiling as knee
        '{10'd100, 10'd800, 8'd24, 4'd8,  4'd15, 10'd1023, 10'd100, 1'b1}, // R9 bypass
        '{10'd500, 10'd500, 8'd40, 4'd8,  4'd15, 10'd1023, 10'd480, 1'b0}, // R4 flat field
        '{10'd300, 10'd700, 8'd24, 4'd0,  4'd12, 10'd1023, 10'd200, 1'b0}, // R10 frac 0
        '{10'd100, 10'd800, 8'd24, 4'd8,  4'd0,  10'd1023, 10'd150, 1'b0}  // R10 gain 0
    };

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_y = 0, m_lo = 1023, m_hi = 0, m_knee = 0;
    bit m_seen = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_pixel(int x);
        m_y = m_y + ((x - m_y) >>> 3);
        if (m_y < m_lo) m_lo = m_y;
        if (m_y > m_hi) m_hi = m_y;
        m_seen = 1'b1;
    endtask

    function automatic int model_out(int x, bit byp);
        int k;
        int v;
        k = (m_knee < int'(cfg_expand_cap)) ? m_knee : int'(cfg_expand_cap);
        v = x;
        if (!byp && x < k) v = x + ((int'(cfg_expand_gain) * (x - k)) >>> 4);
        if (v < 0) v = 0;
        return v;
    endfunction

    task automatic send_pix(int x);
        @(negedge clk);
        in_valid = 1'b1;
        in_luma  = 10'(x);
        bypass   = 1'b0;
        model_pixel(x);
    endtask

    task automatic strobe();
        @(negedge clk);
        in_valid    = 1'b0;
        field_start = 1'b1;
        if (m_seen) m_knee = m_lo + ((int'(cfg_tilt_frac) * (m_hi - m_lo)) >>> 4);
        m_lo = 1023; m_hi = 0; m_seen = 1'b0;
        @(negedge clk);
        field_start = 1'b0;
    endtask

    task automatic probe(int x, bit byp, string req);
        int exp_v;
        exp_v = model_out(x, byp);
        @(negedge clk);
        in_valid = 1'b1;
        in_luma  = 10'(x);
        bypass   = byp;
        model_pixel(x);
        @(negedge clk);
        in_valid = 1'b0;
        bypass   = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 latency early", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R2 latency valid", int'(out_valid), 1);
        check(int'(out_luma) == exp_v, req, int'(out_luma), exp_v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        cfg_expand_gain = 4'd15;
        probe(300, 1'b0, "R1 knee zero after reset");

        // R3: single-sample field pins the smoothed value as the knee
        cfg_tilt_frac = 4'd15;
        strobe();
        send_pix(800);
        strobe();
        probe(60, 1'b0, "R3 filter recurrence");

        // table of field patterns and probes
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_tilt_frac   = VECS[i].frac;
            cfg_expand_gain = VECS[i].gain;
            cfg_expand_cap  = VECS[i].cap;
            strobe();
            for (int j = 0; j < int'(VECS[i].n); j++) send_pix(int'(VECS[i].lo));
            for (int j = 0; j < int'(VECS[i].n); j++) send_pix(int'(VECS[i].hi));
            strobe();
            probe(int'(VECS[i].probe), VECS[i].byp, $sformatf("R4 R6 vector %0d", i));
        end

        // R5: empty field keeps the knee
        cfg_tilt_frac   = 4'd12;
        cfg_expand_gain = 4'd10;
        cfg_expand_cap  = 10'd1023;
        strobe();
        for (int j = 0; j < 20; j++) send_pix(200);
        for (int j = 0; j < 20; j++) send_pix(900);
        strobe();
        strobe();
        probe(300, 1'b0, "R5 empty field holds knee");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule